// File: doc/BRIEF.md
# SATA Host Adapter Register File

This block is the register file of a multi-port SATA host adapter. Software reaches it through a simple 32-bit register bus. The bus has a request valid, a write flag, a byte address and write data. Read data and an error flag come back combinationally in the same cycle. Write effects appear from the next clock edge.

The block has three global registers: a capability word, a host control word and a port presence mask. It also has one register bank per port, holding the command list base, receive-area base, command, interrupt status, error, active and command-issue registers. Each register follows its own access rule: plain, read-only, write-one-to-clear, or set-only. The transfer engines that surround the block see the two base addresses as 64-bit outputs. They drive per-port strobes that set interrupt and error bits and retire command slots. A single interrupt line combines the interrupt status of every port, gated by a global enable.

Top module: `hba_regbank`

## Requirements
- R1: A read of global offset 0x00 returns NUM_PORTS-1 in bits 4:0 and NUM_SLOTS-1 in bits 12:8. All other bits, including bit 30 (command queuing support), read as 0.
- R2: A read of global offset 0x0C returns a mask with the low NUM_PORTS bits set and every other bit clear.
- R3: An address below 0x100 selects a global register. For an address at or above 0x100, the port is (address-0x100)/0x80 and the register is the remainder: 0x00 list base low, 0x04 list base high, 0x08 receive base low, 0x0C receive base high, 0x10 interrupt status, 0x18 command, 0x30 error, 0x34 active, 0x38 command issue.
- R4: The access returns rsp_err=1 with rsp_rdata=0 and changes no state when any of these holds: the offset is unmapped, the port is at or beyond NUM_PORTS, or the write targets a read-only register (offsets 0x00 and 0x0C in the global region, active register 0x34 in a bank).
- R5: The host control register is at global offset 0x04. Its reset bit is bit 0, its interrupt-enable bit is bit 1 and its adapter-enable bit is bit 31. A write with both bit 0 and bit 31 set returns rsp_err=1 and leaves the register unchanged.
- R6: Any other host control write stores the written value with bit 0 forced to 0. If the write has bit 0 set while the stored bit 31 is already 1, rst_warn is 1 for the cycle after that write. Otherwise rst_warn is 0.
- R7: A write to interrupt status or to the error register clears exactly the bits written as 1. Bits set by the matching hardware strobe in the same cycle end up set, so the hardware set wins.
- R8: A write to command issue ORs the written bits into the register and never clears a bit. hw_ci_clr clears bits. A bit that software sets in the same cycle as the hardware clear ends up set.
- R9: cl_base of each port is {list base high, list base low} with bits 9:0 forced to 0. fis_base is {receive base high, receive base low} with bits 7:0 forced to 0. Both registers read back the stored, masked value.
- R10: The command register reads back what was last written, and port_cmd shows it. The active register reads as the port's slice of sact_in.
- R11: irq is host control bit 1 ANDed with the OR of every bit of every port's interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access rejected |
| ghc_ctl | output | 32 | Stored host control word |
| rst_warn | output | 1 | Reset requested while enabled (one cycle) |
| irq | output | 1 | Summary interrupt |
| hw_is_set | input | NUM_PORTS*32 | Per-port interrupt status set strobes |
| hw_serr_set | input | NUM_PORTS*32 | Per-port error set strobes |
| hw_ci_clr | input | NUM_PORTS*32 | Per-port command slot completion strobes |
| sact_in | input | NUM_PORTS*32 | Per-port active slot state |
| cl_base | output | NUM_PORTS*64 | Per-port command list base |
| fis_base | output | NUM_PORTS*64 | Per-port receive area base |
| port_cmd | output | NUM_PORTS*32 | Per-port command register |
| cmd_issue | output | NUM_PORTS*32 | Per-port command issue register |

## Verification
The assertions check properties that must hold on every cycle:
- a set-only command issue bit never drops except under a completion strobe;
- a hardware interrupt set is always visible on the next cycle;
- an error response always carries zero data;
- a rejected host control write leaves the register untouched;
- the interrupt line and the warning flag have a legitimate cause.

Only the bench's scenarios can show the following:
- the exact decoded values and the port index arithmetic across every bank;
- the alignment masking;
- the value stored after a reset request;
- the outcome when software and hardware touch the same bit in the same cycle.

// File: rtl/hba_reg_pkg.sv
// Package: shared offsets, bit positions and register identifiers for the
// host adapter register file. Assumes 32-bit registers and byte addresses.
package hba_reg_pkg;

    localparam int GOFF_CAP    = 'h00;
    localparam int GOFF_GHC    = 'h04;
    localparam int GOFF_PI     = 'h0C;
    localparam int PORT_BASE   = 'h100;
    localparam int BANK_STRIDE = 'h80;

    localparam int BOFF_CLB  = 'h00;
    localparam int BOFF_CLBU = 'h04;
    localparam int BOFF_FB   = 'h08;
    localparam int BOFF_FBU  = 'h0C;
    localparam int BOFF_IS   = 'h10;
    localparam int BOFF_CMD  = 'h18;
    localparam int BOFF_SERR = 'h30;
    localparam int BOFF_SACT = 'h34;
    localparam int BOFF_CI   = 'h38;

    localparam int GHC_HR_BIT = 0;
    localparam int GHC_IE_BIT = 1;
    localparam int GHC_AE_BIT = 31;

    localparam int CLB_ALIGN_BITS = 10;
    localparam int FB_ALIGN_BITS  = 8;

    typedef enum logic [3:0] {
        RID_NONE, RID_CAP, RID_GHC, RID_PI,
        RID_CLB, RID_CLBU, RID_FB, RID_FBU,
        RID_IS, RID_CMD, RID_SERR, RID_SACT, RID_CI
    } reg_id_e;

endpackage

// File: rtl/hba_addr_decode.sv
// Address decoder: splits a byte address into the global region or a port
// bank and names the register addressed. Assumes BANK_STRIDE is a power of
// two and that PORT_BASE fits in ADDR_W bits.
module hba_addr_decode
    import hba_reg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4,
    parameter int PIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           rid,
    output logic [PIDX_W-1:0] pidx,
    output logic              port_ok
);
    localparam int BANK_BITS = $clog2(BANK_STRIDE);
    localparam int RAW_W     = ADDR_W - BANK_BITS;

    logic [ADDR_W-1:0] rebased;
    logic [RAW_W-1:0]  raw_idx;

    // Rebase into the port region and divide by the bank stride.
    always_comb begin
        rebased = addr - ADDR_W'(PORT_BASE);
        raw_idx = rebased[ADDR_W-1:BANK_BITS];
    end

    // Pick the global register or the register inside a bank.
    always_comb begin
        rid     = RID_NONE;
        pidx    = '0;
        port_ok = 1'b0;
        if (addr < ADDR_W'(PORT_BASE)) begin
            case (addr)
                ADDR_W'(GOFF_CAP): rid = RID_CAP;
                ADDR_W'(GOFF_GHC): rid = RID_GHC;
                ADDR_W'(GOFF_PI):  rid = RID_PI;
                default:           rid = RID_NONE;
            endcase
        end else begin
            port_ok = (raw_idx < RAW_W'(NUM_PORTS));
            pidx    = PIDX_W'(raw_idx);
            case (rebased[BANK_BITS-1:0])
                BANK_BITS'(BOFF_CLB):  rid = RID_CLB;
                BANK_BITS'(BOFF_CLBU): rid = RID_CLBU;
                BANK_BITS'(BOFF_FB):   rid = RID_FB;
                BANK_BITS'(BOFF_FBU):  rid = RID_FBU;
                BANK_BITS'(BOFF_IS):   rid = RID_IS;
                BANK_BITS'(BOFF_CMD):  rid = RID_CMD;
                BANK_BITS'(BOFF_SERR): rid = RID_SERR;
                BANK_BITS'(BOFF_SACT): rid = RID_SACT;
                BANK_BITS'(BOFF_CI):   rid = RID_CI;
                default:               rid = RID_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hba_global_regs.sv
// Global registers: the constant capability and presence words, and the
// host control word. Assumes ghc_we is raised only for accepted writes
// (the rejected reset-plus-enable combination is filtered above).
module hba_global_regs
    import hba_reg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SLOTS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ghc_we,
    input  logic [31:0] wdata,
    output logic [31:0] cap_val,
    output logic [31:0] pi_val,
    output logic [31:0] ghc_q,
    output logic        warn_q
);
    localparam logic [31:0] CAP_WORD = (32'(NUM_SLOTS - 1) << 8) | 32'(NUM_PORTS - 1);
    localparam logic [31:0] PI_WORD  = 32'((64'd1 << NUM_PORTS) - 64'd1);

    assign cap_val = CAP_WORD;
    assign pi_val  = PI_WORD;

    // Store host control; the reset request completes at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghc_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            warn_q <= ghc_we && wdata[GHC_HR_BIT] && ghc_q[GHC_AE_BIT];
            if (ghc_we) begin
                ghc_q <= wdata & ~(32'd1 << GHC_HR_BIT);
            end
        end
    end
endmodule

// File: rtl/hba_port_bank.sv
// One port's register bank. Assumes `we` is raised only for an accepted
// write to this port. Hardware sets win over software clears; a software
// command issue set wins over a hardware completion clear.
module hba_port_bank
    import hba_reg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  reg_id_e     rid,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_is_set,
    input  logic [31:0] hw_serr_set,
    input  logic [31:0] hw_ci_clr,
    input  logic [31:0] sact_in,
    output logic [31:0] rdata,
    output logic [63:0] cl_base,
    output logic [63:0] fis_base,
    output logic [31:0] cmd_q,
    output logic [31:0] is_q,
    output logic [31:0] ci_q
);
    localparam logic [31:0] CLB_MASK = ~((32'd1 << CLB_ALIGN_BITS) - 32'd1);
    localparam logic [31:0] FB_MASK  = ~((32'd1 << FB_ALIGN_BITS) - 32'd1);

    logic [31:0] clb_q, clbu_q, fb_q, fbu_q, serr_q;

    // Base address words and the command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clb_q  <= '0;
            clbu_q <= '0;
            fb_q   <= '0;
            fbu_q  <= '0;
            cmd_q  <= '0;
        end else if (we) begin
            case (rid)
                RID_CLB:  clb_q  <= wdata & CLB_MASK;
                RID_CLBU: clbu_q <= wdata;
                RID_FB:   fb_q   <= wdata & FB_MASK;
                RID_FBU:  fbu_q  <= wdata;
                RID_CMD:  cmd_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Write-one-to-clear status, set-only issue, with hardware strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_q   <= '0;
            serr_q <= '0;
            ci_q   <= '0;
        end else begin
            is_q   <= (is_q & ~((we && rid == RID_IS) ? wdata : 32'd0)) | hw_is_set;
            serr_q <= (serr_q & ~((we && rid == RID_SERR) ? wdata : 32'd0)) | hw_serr_set;
            ci_q   <= (ci_q & ~hw_ci_clr) | ((we && rid == RID_CI) ? wdata : 32'd0);
        end
    end

    // Read-back selection.
    always_comb begin
        case (rid)
            RID_CLB:  rdata = clb_q;
            RID_CLBU: rdata = clbu_q;
            RID_FB:   rdata = fb_q;
            RID_FBU:  rdata = fbu_q;
            RID_IS:   rdata = is_q;
            RID_CMD:  rdata = cmd_q;
            RID_SERR: rdata = serr_q;
            RID_SACT: rdata = sact_in;
            RID_CI:   rdata = ci_q;
            default:  rdata = '0;
        endcase
    end

    assign cl_base  = {clbu_q, clb_q};
    assign fis_base = {fbu_q, fb_q};
endmodule

// File: rtl/hba_regbank.sv
// Top of the host adapter register file: decodes the bus, screens illegal
// accesses, routes writes to the global block or one port bank and muxes
// read data. Assumes NUM_PORTS fits the port region of the ADDR_W space.
module hba_regbank
    import hba_reg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [31:0]             req_wdata,
    output logic [31:0]             rsp_rdata,
    output logic                    rsp_err,
    output logic [31:0]             ghc_ctl,
    output logic                    rst_warn,
    output logic                    irq,
    input  logic [NUM_PORTS*32-1:0] hw_is_set,
    input  logic [NUM_PORTS*32-1:0] hw_serr_set,
    input  logic [NUM_PORTS*32-1:0] hw_ci_clr,
    input  logic [NUM_PORTS*32-1:0] sact_in,
    output logic [NUM_PORTS*64-1:0] cl_base,
    output logic [NUM_PORTS*64-1:0] fis_base,
    output logic [NUM_PORTS*32-1:0] port_cmd,
    output logic [NUM_PORTS*32-1:0] cmd_issue
);
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    reg_id_e           rid;
    logic [PIDX_W-1:0] pidx;
    logic              port_ok;
    logic              is_port, ro_target, bad_ghc, ok_wr;
    logic [31:0]       cap_val, pi_val;
    logic [31:0]       bank_rd [NUM_PORTS];
    logic [NUM_PORTS*32-1:0] is_flat;

    hba_addr_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_dec (
        .addr(req_addr), .rid(rid), .pidx(pidx), .port_ok(port_ok)
    );

    // Classify the access and decide whether it is rejected.
    always_comb begin
        is_port   = (rid inside {RID_CLB, RID_CLBU, RID_FB, RID_FBU, RID_IS,
                                 RID_CMD, RID_SERR, RID_SACT, RID_CI});
        ro_target = (rid inside {RID_CAP, RID_PI, RID_SACT});
        bad_ghc   = (rid == RID_GHC) && req_wdata[GHC_HR_BIT] && req_wdata[GHC_AE_BIT];
        rsp_err   = req_valid && ((rid == RID_NONE) || (is_port && !port_ok) ||
                                  (req_write && (ro_target || bad_ghc)));
        ok_wr     = req_valid && req_write && !rsp_err;
    end

    hba_global_regs #(.NUM_PORTS(NUM_PORTS), .NUM_SLOTS(NUM_SLOTS)) u_glob (
        .clk(clk), .rst_n(rst_n), .ghc_we(ok_wr && rid == RID_GHC),
        .wdata(req_wdata), .cap_val(cap_val), .pi_val(pi_val),
        .ghc_q(ghc_ctl), .warn_q(rst_warn)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hba_port_bank u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(ok_wr && is_port && (pidx == PIDX_W'(p))),
            .rid(rid), .wdata(req_wdata),
            .hw_is_set(hw_is_set[p*32 +: 32]),
            .hw_serr_set(hw_serr_set[p*32 +: 32]),
            .hw_ci_clr(hw_ci_clr[p*32 +: 32]),
            .sact_in(sact_in[p*32 +: 32]),
            .rdata(bank_rd[p]),
            .cl_base(cl_base[p*64 +: 64]),
            .fis_base(fis_base[p*64 +: 64]),
            .cmd_q(port_cmd[p*32 +: 32]),
            .is_q(is_flat[p*32 +: 32]),
            .ci_q(cmd_issue[p*32 +: 32])
        );
    end

    // Read data: zero for writes and rejected accesses.
    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write && !rsp_err) begin
            case (rid)
                RID_CAP: rsp_rdata = cap_val;
                RID_GHC: rsp_rdata = ghc_ctl;
                RID_PI:  rsp_rdata = pi_val;
                default: begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (pidx == PIDX_W'(p)) rsp_rdata = bank_rd[p];
                    end
                end
            endcase
        end
    end

    assign irq = ghc_ctl[GHC_IE_BIT] && (|is_flat);
endmodule

// File: rtl/hba_regbank_chk.sv
// Checker for hba_regbank: cycle-level properties over its ports and the
// per-port interrupt status vector. Attached with the bind below.
module hba_regbank_chk
    import hba_reg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [ADDR_W-1:0]       req_addr,
    input logic [31:0]             req_wdata,
    input logic [31:0]             rsp_rdata,
    input logic                    rsp_err,
    input logic [31:0]             ghc_ctl,
    input logic                    rst_warn,
    input logic                    irq,
    input logic [NUM_PORTS*32-1:0] hw_is_set,
    input logic [NUM_PORTS*32-1:0] hw_ci_clr,
    input logic [NUM_PORTS*32-1:0] cmd_issue,
    input logic [NUM_PORTS*32-1:0] is_flat
);
    logic ghc_bad_wr;
    assign ghc_bad_wr = req_valid && req_write && (req_addr == ADDR_W'(GOFF_GHC)) &&
                        req_wdata[GHC_HR_BIT] && req_wdata[GHC_AE_BIT];

    AST_BAD_GHC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ghc_bad_wr |-> rsp_err); // R5
    AST_BAD_GHC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ghc_bad_wr |=> $stable(ghc_ctl)); // R5
    AST_RO_CAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(GOFF_CAP)) |-> rsp_err); // R4
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0)); // R4
    AST_CI_NO_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cmd_issue) & ~$past(hw_ci_clr)) & ~cmd_issue) == '0)); // R8
    AST_IS_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((is_flat & $past(hw_is_set)) == $past(hw_is_set))); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ghc_ctl[GHC_IE_BIT] && (|is_flat))); // R11
    AST_WARN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_warn |-> $past(ghc_ctl[GHC_AE_BIT])); // R6
endmodule

bind hba_regbank hba_regbank_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ghc_ctl(ghc_ctl), .rst_warn(rst_warn), .irq(irq),
    .hw_is_set(hw_is_set), .hw_ci_clr(hw_ci_clr), .cmd_issue(cmd_issue),
    .is_flat(is_flat)
);

// File: tb/hba_regbank_tb.sv
module hba_regbank_tb;
    localparam int NP = 3;
    localparam int NS = 8;
    localparam int AW = 12;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic rsp_err, rst_warn, irq;
    logic [31:0] ghc_ctl;
    logic [NP*32-1:0] hw_is_set = '0, hw_serr_set = '0, hw_ci_clr = '0, sact_in = '0;
    logic [NP*64-1:0] cl_base, fis_base;
    logic [NP*32-1:0] port_cmd, cmd_issue;

    int total = 0;
    int bad = 0;
    logic [31:0] rd;
    logic er;

    always #4 clk = ~clk;

    hba_regbank #(.NUM_PORTS(NP), .NUM_SLOTS(NS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .ghc_ctl(ghc_ctl), .rst_warn(rst_warn), .irq(irq),
        .hw_is_set(hw_is_set), .hw_serr_set(hw_serr_set), .hw_ci_clr(hw_ci_clr),
        .sact_in(sact_in), .cl_base(cl_base), .fis_base(fis_base),
        .port_cmd(port_cmd), .cmd_issue(cmd_issue)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        #2 e = rsp_err;
        @(posedge clk);
        #1 req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        #2 d = rsp_rdata; e = rsp_err;
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    function automatic logic [AW-1:0] padr(input int p, input int off);
        return AW'('h100 + p * 'h80 + off);
    endfunction

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1 check("reset irq", irq, 0);
        check("reset ghc", ghc_ctl, 0);
        check("reset cl_base", cl_base, 0);

        bus_rd(AW'('h00), rd, er);
        check("R1 cap", {er, rd}, {1'b0, 32'(((NS - 1) << 8) | (NP - 1))});
        bus_rd(AW'('h0C), rd, er);
        check("R2 pi", {er, rd}, {1'b0, 32'((1 << NP) - 1)});

        // R3 R9 R10 sweep of every bank
        for (int p = 0; p < NP; p++) begin
            bus_wr(padr(p, 'h00), 32'hFFFF_FFFF, er);
            bus_wr(padr(p, 'h04), 32'hA000_0000 + p, er);
            bus_wr(padr(p, 'h08), 32'hFFFF_FFFF, er);
            bus_wr(padr(p, 'h0C), 32'hB000_0000 + p, er);
            bus_wr(padr(p, 'h18), 32'h1234_0000 + p, er);
            bus_rd(padr(p, 'h00), rd, er);
            check("R9 clb read", rd, 32'hFFFF_FC00);
            bus_rd(padr(p, 'h08), rd, er);
            check("R9 fb read", rd, 32'hFFFF_FF00);
            bus_rd(padr(p, 'h04), rd, er);
            check("R3 clbu read", rd, 32'hA000_0000 + p);
            check("R9 cl_base", cl_base[p*64 +: 64], {32'hA000_0000 + p, 32'hFFFF_FC00});
            check("R9 fis_base", fis_base[p*64 +: 64], {32'hB000_0000 + p, 32'hFFFF_FF00});
            bus_rd(padr(p, 'h18), rd, er);
            check("R10 cmd read", rd, 32'h1234_0000 + p);
            check("R10 port_cmd", port_cmd[p*32 +: 32], 32'h1234_0000 + p);
            sact_in[p*32 +: 32] = 32'h5A00 + p;
            bus_rd(padr(p, 'h34), rd, er);
            check("R10 sact read", rd, 32'h5A00 + p);
        end

        // R4 error cases
        bus_rd(padr(NP, 'h00), rd, er);
        check("R4 port out of range", {er, rd}, {1'b1, 32'd0});
        bus_wr(padr(NP, 'h18), 32'hFFFF, er);
        check("R4 write port out of range", er, 1);
        bus_rd(padr(0, 'h14), rd, er);
        check("R4 unmapped bank", {er, rd}, {1'b1, 32'd0});
        bus_rd(AW'('h08), rd, er);
        check("R4 unmapped global", {er, rd}, {1'b1, 32'd0});
        bus_wr(AW'('h00), 32'hFFFF_FFFF, er);
        check("R4 cap write err", er, 1);
        bus_rd(AW'('h00), rd, er);
        check("R4 cap unchanged", rd, 32'(((NS - 1) << 8) | (NP - 1)));
        bus_wr(padr(1, 'h34), 32'h0, er);
        check("R4 sact write err", er, 1);
        bus_rd(padr(1, 'h34), rd, er);
        check("R4 sact unchanged", rd, 32'h5A01);
        for (int p = 0; p < NP; p++)
            check("R4 cmd untouched", port_cmd[p*32 +: 32], 32'h1234_0000 + p);

        // R5 R6 host control
        bus_wr(AW'('h04), 32'h8000_0001, er);
        check("R5 hr+ae err", er, 1);
        check("R5 ghc unchanged", ghc_ctl, 0);
        bus_wr(AW'('h04), 32'h8000_0002, er);
        check("R6 no warn", rst_warn, 0);
        bus_rd(AW'('h04), rd, er);
        check("R6 ghc store", rd, 32'h8000_0002);
        bus_wr(AW'('h04), 32'h8000_0001, er);
        check("R5 rejected while enabled", {er, ghc_ctl}, {1'b1, 32'h8000_0002});
        bus_wr(AW'('h04), 32'h0000_0003, er);
        check("R6 warn when enabled", {er, rst_warn}, {1'b0, 1'b1});
        check("R6 hr self-clear", ghc_ctl, 32'h0000_0002);
        bus_wr(AW'('h04), 32'h0000_0003, er);
        check("R6 no warn when disabled", {rst_warn, ghc_ctl}, {1'b0, 32'h2});

        // R7 R11 interrupt status
        check("R11 idle irq", irq, 0);
        @(negedge clk); hw_is_set[32 +: 32] = 32'hF0;
        @(posedge clk); #1 hw_is_set = '0;
        bus_rd(padr(1, 'h10), rd, er);
        check("R7 hw set", rd, 32'hF0);
        check("R11 irq on", irq, 1);
        bus_wr(padr(1, 'h10), 32'h30, er);
        bus_rd(padr(1, 'h10), rd, er);
        check("R7 w1c", rd, 32'hC0);
        hw_is_set[32 +: 32] = 32'h10;
        bus_wr(padr(1, 'h10), 32'h50, er);
        hw_is_set = '0;
        bus_rd(padr(1, 'h10), rd, er);
        check("R7 hw set wins", rd, 32'h90);
        bus_wr(AW'('h04), 32'h0, er);
        check("R11 ie off", irq, 0);
        bus_wr(AW'('h04), 32'h2, er);
        bus_wr(padr(1, 'h10), 32'hFFFF_FFFF, er);
        check("R11 irq cleared", irq, 0);

        // R7 error register
        @(negedge clk); hw_serr_set[64 +: 32] = 32'h0F0F;
        @(posedge clk); #1 hw_serr_set = '0;
        bus_wr(padr(2, 'h30), 32'h0F00, er);
        bus_rd(padr(2, 'h30), rd, er);
        check("R7 serr w1c", rd, 32'h000F);
        hw_serr_set[64 +: 32] = 32'h1;
        bus_wr(padr(2, 'h30), 32'h3, er);
        hw_serr_set = '0;
        bus_rd(padr(2, 'h30), rd, er);
        check("R7 serr hw wins", rd, 32'h000D);

        // R8 command issue
        bus_wr(padr(0, 'h38), 32'h5, er);
        bus_wr(padr(0, 'h38), 32'h2, er);
        bus_rd(padr(0, 'h38), rd, er);
        check("R8 or-set", rd, 32'h7);
        bus_wr(padr(0, 'h38), 32'h0, er);
        check("R8 no sw clear", cmd_issue[0 +: 32], 32'h7);
        @(negedge clk); hw_ci_clr[0 +: 32] = 32'h1;
        @(posedge clk); #1 hw_ci_clr = '0;
        check("R8 hw clear", cmd_issue[0 +: 32], 32'h6);
        hw_ci_clr[0 +: 32] = 32'h4;
        bus_wr(padr(0, 'h38), 32'h4, er);
        hw_ci_clr = '0;
        bus_rd(padr(0, 'h38), rd, er);
        check("R8 sw set wins", rd, 32'h6);
        check("R8 other port idle", cmd_issue[32 +: 64], 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule